// File: doc/BRIEF.md
# Peripheral Compartment Access Filter

This block is a register-programmed firewall that sits beside a peripheral bus and decides, for each access aimed at one of up to 128 peripheral slots, whether it may pass. Each access carries a compartment identifier (CID, 3 bits), a secure flag and a privileged flag. The filter compares them with the slot's programmed rules. There are two packed bitmaps, one marking slots as secure-only and one marking slots as privileged-only. Each slot also has a configuration word that turns on CID filtering and chooses between two kinds of ownership. One kind names a fixed owner CID. The other is a hardware semaphore that only compartments on the slot's whitelist may take.

Software programs the filter through a simple 32-bit word-addressed register port. The CID of the writer is presented with each write, so the semaphore knows who is taking or releasing it. A read-only word reports how many slots, bus masters and memory regions the instance was built with. The live holder state of every semaphore is also brought out, for use by the neighbouring logic.

Top module: `periph_fw`

## Requirements
- R1: After reset, every configuration word, bitmap word and semaphore reads 0, sem_held is all zero, and every in-range access is granted.
- R2: The secure bitmap for slot n is bit n%32 of the word at 0x010 + 4*(n/32). When that bit is set, an access with acc_sec=0 is denied.
- R3: The privileged bitmap for slot n is bit n%32 of the word at 0x030 + 4*(n/32). When that bit is set, an access with acc_priv=0 is denied.
- R4: The configuration word of slot n is at 0x100 + 8*n, with these fields: bit 0 filter enable, bit 1 semaphore mode, bits 6:4 fixed owner CID, and bits 23:16 a whitelist in which bit 16+c stands for CID c. All other bits read back as 0.
- R5: When a slot's filter enable is 0, the CID is not checked. Only R2 and R3 apply.
- R6: When filtering is on and semaphore mode is off, an access is granted only if acc_cid equals the fixed owner CID.
- R7: When filtering is on and semaphore mode is on, the fixed owner CID is ignored. An access is granted only if acc_cid is whitelisted and currently holds the slot's semaphore.
- R8: The semaphore of slot n is at 0x104 + 8*n. In semaphore mode, a write with bit 0 set by a whitelisted CID takes a free semaphore. The read-back then has bit 0 = 1 and bits 6:4 = the holder's CID, and sem_held[n] and sem_owner[3n+2:3n] show the same state.
- R9: When the holder writes bit 0 = 1 again, the semaphore is released. It then reads 0, and another whitelisted CID can take it on its next write.
- R10: A semaphore write is ignored if bit 0 is 0, if the writer is not whitelisted, if semaphore mode is off, or if the semaphore is held by another CID. Without a register write, the semaphore state never changes.
- R11: The word at 0xFEC reads {regions[7:0], masters[7:0], slots[15:0]}. With the default parameters this is 0x02100028.
- R12: An access to a slot number of NUM_PERIPH or above is always denied. Unmapped or misaligned addresses, and bitmap words with no slots behind them, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_cid | input | 3 | CID of the compartment doing the register write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| acc_slot | input | 7 | Peripheral slot targeted by the filtered access |
| acc_cid | input | 3 | CID of the filtered access |
| acc_sec | input | 1 | Filtered access is secure |
| acc_priv | input | 1 | Filtered access is privileged |
| acc_grant | output | 1 | 1 = the access may pass, 0 = it is denied |
| sem_held | output | NUM_PERIPH | Per-slot semaphore taken flag |
| sem_owner | output | 3*NUM_PERIPH | Per-slot holder CID, 0 when free |

## Verification
The hardest state to reach is a semaphore slot whose grant depends on both the whitelist and the current holder, while rejected attempts must leave that holder unchanged. The bench drives a scripted sequence of semaphore writes on one slot: a CID that is not whitelisted, a take, a rival's attempt, a write with bit 0 clear, a release and a hand-over to a second CID. A write to a slot with semaphore mode off is mixed in. After every step it sweeps all slots against every CID and flag combination, and reads back every register, against an arithmetic model.

// File: rtl/fw_pkg.sv
package fw_pkg;
   localparam int CID_W     = 3;
   localparam int NUM_CID   = 1 << CID_W;
   localparam int ADDR_W    = 12;
   localparam int IDX_W     = 7;
   localparam int MAX_SLOTS = 1 << IDX_W;

   localparam logic [ADDR_W-1:0] SEC_BASE  = 12'h010;
   localparam logic [ADDR_W-1:0] PRIV_BASE = 12'h030;
   localparam logic [ADDR_W-1:0] SLOT_BASE = 12'h100;
   localparam logic [ADDR_W-1:0] HW_ADDR   = 12'hFEC;

   typedef struct packed {
      logic [NUM_CID-1:0] wl;
      logic [CID_W-1:0]   scid;
      logic               sem_en;
      logic               flt_en;
   } slot_cfg_t;

   function automatic logic [31:0] cfg_word(slot_cfg_t c);
      return {8'h00, c.wl, 9'h000, c.scid, 2'b00, c.sem_en, c.flt_en};
   endfunction

   function automatic logic [31:0] sem_word(logic held, logic [CID_W-1:0] own);
      return {25'h0, own, 3'b000, held};
   endfunction
endpackage

// File: rtl/fw_slot.sv
module fw_slot
   import fw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             sem_we,
   input  slot_cfg_t        wr_cfg,
   input  logic             wr_mutex,
   input  logic [CID_W-1:0] wr_cid,
   output slot_cfg_t        cfg,
   output logic             held,
   output logic [CID_W-1:0] owner
);
   logic touch;

   assign touch = sem_we & wr_mutex & cfg.sem_en & cfg.wl[wr_cid];

   always_ff @(posedge clk) begin
      if (!rst_n) cfg <= '0;
      else if (cfg_we) cfg <= wr_cfg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held  <= 1'b0;
         owner <= '0;
      end else if (touch) begin
         if (!held) begin
            held  <= 1'b1;
            owner <= wr_cid;
         end else if (owner == wr_cid) begin
            held  <= 1'b0;
            owner <= '0;
         end
      end
   end
endmodule

// File: rtl/fw_bitmap.sv
module fw_bitmap #(
   parameter int NUM_PERIPH = 40
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [(NUM_PERIPH+31)/32-1:0]  grp_we,
   input  logic [31:0]                    wdata,
   output logic [NUM_PERIPH-1:0]          map
);
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) map[i] <= 1'b0;
         else if (grp_we[i/32]) map[i] <= wdata[i%32];
      end
   end
endmodule

// File: rtl/fw_regif.sv
module fw_regif
   import fw_pkg::*;
#(
   parameter int NUM_PERIPH  = 40,
   parameter int NUM_MASTERS = 16,
   parameter int NUM_REGIONS = 2
) (
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  slot_cfg_t [NUM_PERIPH-1:0]    cfg_all,
   input  logic [NUM_PERIPH-1:0]         sem_held,
   input  logic [NUM_PERIPH*CID_W-1:0]   sem_owner,
   input  logic [NUM_PERIPH-1:0]         sec_map,
   input  logic [NUM_PERIPH-1:0]         priv_map,
   output logic [NUM_PERIPH-1:0]         cfg_we,
   output logic [NUM_PERIPH-1:0]         sem_we,
   output logic [(NUM_PERIPH+31)/32-1:0] sec_we,
   output logic [(NUM_PERIPH+31)/32-1:0] priv_we,
   output logic [31:0]                   rdata
);
   localparam int NUM_GROUPS = (NUM_PERIPH + 31) / 32;
   localparam logic [31:0] HW_WORD = {8'(NUM_REGIONS), 8'(NUM_MASTERS), 16'(NUM_PERIPH)};

   logic [ADDR_W-1:0] slot_off, sec_off, priv_off;
   logic              in_slot, in_sec, in_priv;
   logic [NUM_GROUPS*32-1:0] sec_pad, priv_pad;
   logic [31:0] slot_rd [NUM_PERIPH+1];
   logic [31:0] grp_rd  [NUM_GROUPS+1];

   assign slot_off = bus_addr - SLOT_BASE;
   assign sec_off  = bus_addr - SEC_BASE;
   assign priv_off = bus_addr - PRIV_BASE;
   assign in_slot  = (bus_addr >= SLOT_BASE) && (slot_off[1:0] == 2'b00);
   assign in_sec   = (bus_addr >= SEC_BASE)  && (sec_off[1:0]  == 2'b00);
   assign in_priv  = (bus_addr >= PRIV_BASE) && (priv_off[1:0] == 2'b00);
   assign sec_pad  = (NUM_GROUPS*32)'(sec_map);
   assign priv_pad = (NUM_GROUPS*32)'(priv_map);

   assign slot_rd[0] = '0;
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
      logic hit;
      assign hit       = in_slot && (slot_off[ADDR_W-1:3] == (ADDR_W-3)'(i));
      assign cfg_we[i] = bus_we && hit && !slot_off[2];
      assign sem_we[i] = bus_we && hit &&  slot_off[2];
      assign slot_rd[i+1] = slot_rd[i] |
         (!hit ? 32'h0 :
          slot_off[2] ? sem_word(sem_held[i], sem_owner[i*CID_W +: CID_W])
                      : cfg_word(cfg_all[i]));
   end

   assign grp_rd[0] = '0;
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit_s, hit_p;
      assign hit_s = in_sec  && (sec_off[ADDR_W-1:2]  == (ADDR_W-2)'(g));
      assign hit_p = in_priv && (priv_off[ADDR_W-1:2] == (ADDR_W-2)'(g));
      assign sec_we[g]  = bus_we && hit_s;
      assign priv_we[g] = bus_we && hit_p;
      assign grp_rd[g+1] = grp_rd[g] |
         (hit_s ? sec_pad[g*32 +: 32] : 32'h0) |
         (hit_p ? priv_pad[g*32 +: 32] : 32'h0);
   end

   assign rdata = slot_rd[NUM_PERIPH] | grp_rd[NUM_GROUPS] |
                  ((bus_addr == HW_ADDR) ? HW_WORD : 32'h0);
endmodule

// File: rtl/periph_fw.sv
module periph_fw
   import fw_pkg::*;
#(
   parameter int NUM_PERIPH  = 40,
   parameter int NUM_MASTERS = 16,
   parameter int NUM_REGIONS = 2,
   parameter int REG_GRANT   = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [31:0]                 bus_wdata,
   input  logic [CID_W-1:0]            bus_cid,
   output logic [31:0]                 bus_rdata,
   input  logic [IDX_W-1:0]            acc_slot,
   input  logic [CID_W-1:0]            acc_cid,
   input  logic                        acc_sec,
   input  logic                        acc_priv,
   output logic                        acc_grant,
   output logic [NUM_PERIPH-1:0]       sem_held,
   output logic [NUM_PERIPH*CID_W-1:0] sem_owner
);
   localparam int NUM_GROUPS = (NUM_PERIPH + 31) / 32;

   if (NUM_PERIPH < 1 || NUM_PERIPH > MAX_SLOTS) begin : g_bad_slots
      $error("periph_fw: NUM_PERIPH must lie in 1..128");
   end
   if (NUM_MASTERS < 0 || NUM_MASTERS > 255 || NUM_REGIONS < 0 || NUM_REGIONS > 255) begin : g_bad_cnt
      $error("periph_fw: master and region counts must fit in 8 bits");
   end
   if (NUM_GROUPS > 4) begin : g_bad_map
      $error("periph_fw: bitmap windows would overlap");
   end

   slot_cfg_t [NUM_PERIPH-1:0] cfg_all;
   slot_cfg_t                  wr_cfg;
   logic [NUM_PERIPH-1:0]      cfg_we, sem_we, sec_map, priv_map;
   logic [NUM_GROUPS-1:0]      sec_we, priv_we;
   logic [MAX_SLOTS-1:0]       sec_full, priv_full, held_full;

   assign wr_cfg = '{wl: bus_wdata[23:16], scid: bus_wdata[6:4],
                     sem_en: bus_wdata[1], flt_en: bus_wdata[0]};

   fw_regif #(.NUM_PERIPH(NUM_PERIPH), .NUM_MASTERS(NUM_MASTERS), .NUM_REGIONS(NUM_REGIONS)) u_regif (
      .bus_we(bus_we), .bus_addr(bus_addr), .cfg_all(cfg_all),
      .sem_held(sem_held), .sem_owner(sem_owner),
      .sec_map(sec_map), .priv_map(priv_map),
      .cfg_we(cfg_we), .sem_we(sem_we), .sec_we(sec_we), .priv_we(priv_we),
      .rdata(bus_rdata));

   fw_bitmap #(.NUM_PERIPH(NUM_PERIPH)) u_sec (
      .clk(clk), .rst_n(rst_n), .grp_we(sec_we), .wdata(bus_wdata), .map(sec_map));
   fw_bitmap #(.NUM_PERIPH(NUM_PERIPH)) u_priv (
      .clk(clk), .rst_n(rst_n), .grp_we(priv_we), .wdata(bus_wdata), .map(priv_map));

   slot_cfg_t        cfg_chain [NUM_PERIPH+1];
   logic [CID_W-1:0] own_chain [NUM_PERIPH+1];
   assign cfg_chain[0] = '0;
   assign own_chain[0] = '0;

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
      logic sel;
      fw_slot u_slot (
         .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[i]), .sem_we(sem_we[i]),
         .wr_cfg(wr_cfg), .wr_mutex(bus_wdata[0]), .wr_cid(bus_cid),
         .cfg(cfg_all[i]), .held(sem_held[i]),
         .owner(sem_owner[i*CID_W +: CID_W]));
      assign sel = (acc_slot == IDX_W'(i));
      assign cfg_chain[i+1] = cfg_chain[i] | (sel ? cfg_all[i] : slot_cfg_t'('0));
      assign own_chain[i+1] = own_chain[i] | (sel ? sem_owner[i*CID_W +: CID_W] : '0);
   end

   assign sec_full  = MAX_SLOTS'(sec_map);
   assign priv_full = MAX_SLOTS'(priv_map);
   assign held_full = MAX_SLOTS'(sem_held);

   slot_cfg_t sel_cfg;
   logic      in_range, attr_ok, cid_ok, grant_now;

   assign sel_cfg   = cfg_chain[NUM_PERIPH];
   assign in_range  = {1'b0, acc_slot} < (IDX_W+1)'(NUM_PERIPH);
   assign attr_ok   = !(sec_full[acc_slot] && !acc_sec) && !(priv_full[acc_slot] && !acc_priv);
   assign cid_ok    = !sel_cfg.flt_en ||
                      (sel_cfg.sem_en ? (sel_cfg.wl[acc_cid] && held_full[acc_slot] &&
                                         own_chain[NUM_PERIPH] == acc_cid)
                                      : (sel_cfg.scid == acc_cid));
   assign grant_now = in_range && attr_ok && cid_ok;

   if (REG_GRANT != 0) begin : g_reg_grant
      always_ff @(posedge clk) begin
         if (!rst_n) acc_grant <= 1'b0;
         else        acc_grant <= grant_now;
      end
   end else begin : g_comb_grant
      assign acc_grant = grant_now;
   end
endmodule

// File: rtl/fw_check.sv
module fw_check
   import fw_pkg::*;
#(
   parameter int NUM_PERIPH = 40,
   parameter int REG_GRANT  = 0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_we,
   input logic [CID_W-1:0]            bus_cid,
   input logic [IDX_W-1:0]            acc_slot,
   input logic                        acc_sec,
   input logic                        acc_priv,
   input logic                        acc_grant,
   input logic [NUM_PERIPH-1:0]       sem_held,
   input logic [NUM_PERIPH*CID_W-1:0] sem_owner,
   input logic [MAX_SLOTS-1:0]        sec_full,
   input logic [MAX_SLOTS-1:0]        priv_full
);
   assert_reset_free_R1: assert property (@(posedge clk)
      !rst_n |=> (sem_held == '0));

   assert_sem_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(sem_held) && $stable(sem_owner)));

   if (REG_GRANT == 0) begin : g_comb
      assert_deny_nonsec_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_grant && !acc_sec) |-> !sec_full[acc_slot]);
      assert_deny_unpriv_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_grant && !acc_priv) |-> !priv_full[acc_slot]);
      assert_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, acc_slot} >= (IDX_W+1)'(NUM_PERIPH)) |-> !acc_grant);
   end else begin : g_reg
      assert_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, acc_slot} >= (IDX_W+1)'(NUM_PERIPH)) |=> !acc_grant);
   end

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_sem
      assert_take_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sem_held[i]) |-> (sem_owner[i*CID_W +: CID_W] == $past(bus_cid)));
      assert_keep_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (sem_held[i] && $past(sem_held[i])) |-> $stable(sem_owner[i*CID_W +: CID_W]));
   end
endmodule

bind periph_fw fw_check #(.NUM_PERIPH(NUM_PERIPH), .REG_GRANT(REG_GRANT)) u_fw_check (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_cid(bus_cid),
   .acc_slot(acc_slot), .acc_sec(acc_sec), .acc_priv(acc_priv), .acc_grant(acc_grant),
   .sem_held(sem_held), .sem_owner(sem_owner),
   .sec_full(sec_full), .priv_full(priv_full));

// File: tb/periph_fw_test.sv
module periph_fw_test;
   localparam int NP = 40;
   localparam int NG = (NP + 31) / 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [2:0]  bus_cid = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  acc_slot = '0;
   logic [2:0]  acc_cid = '0;
   logic        acc_sec = 1'b0, acc_priv = 1'b0;
   logic        acc_grant;
   logic [NP-1:0]   sem_held;
   logic [NP*3-1:0] sem_owner;

   int errors = 0, checks = 0;
   bit done = 0;

   logic [31:0] m_cfg [NP];
   bit          m_sec [NP], m_priv [NP], m_held [NP];
   logic [2:0]  m_own [NP];

   periph_fw uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_cid(bus_cid), .bus_rdata(bus_rdata),
      .acc_slot(acc_slot), .acc_cid(acc_cid), .acc_sec(acc_sec), .acc_priv(acc_priv),
      .acc_grant(acc_grant), .sem_held(sem_held), .sem_owner(sem_owner));

   always #10 clk = ~clk;

   task automatic model_write(input int a, input logic [31:0] d, input logic [2:0] c);
      if (a >= 256 && a < 256 + 8*NP && a % 4 == 0) begin
         int n = (a - 256) / 8;
         if (a % 8 == 0) m_cfg[n] = d & 32'h00FF_0073;
         else if (d[0] && m_cfg[n][1] && m_cfg[n][16 + c]) begin
            if (!m_held[n]) begin m_held[n] = 1; m_own[n] = c; end
            else if (m_own[n] == c) begin m_held[n] = 0; m_own[n] = 0; end
         end
      end
      for (int g = 0; g < NG; g++)
         for (int b = 0; b < 32; b++)
            if (g*32 + b < NP) begin
               if (a == 16 + 4*g) m_sec[g*32+b] = d[b];
               if (a == 48 + 4*g) m_priv[g*32+b] = d[b];
            end
   endtask

   task automatic wr(input int a, input logic [31:0] d, input logic [2:0] c);
      @(negedge clk);
      bus_we = 1; bus_addr = 12'(a); bus_wdata = d; bus_cid = c;
      @(negedge clk);
      bus_we = 0;
      model_write(a, d, c);
   endtask

   function automatic bit exp_grant(input int s, input int c, input bit sc, input bit pv,
                                    output string tag);
      if (s >= NP) begin tag = "R12"; return 0; end
      if (m_sec[s] && !sc) begin tag = "R2"; return 0; end
      if (m_priv[s] && !pv) begin tag = "R3"; return 0; end
      if (!m_cfg[s][0]) begin tag = "R5"; return 1; end
      if (m_cfg[s][1]) begin
         tag = "R7";
         return m_cfg[s][16 + c] && m_held[s] && m_own[s] == 3'(c);
      end
      tag = "R6";
      return m_cfg[s][6:4] == 3'(c);
   endfunction

   function automatic logic [31:0] exp_read(input int a, output string tag);
      tag = "R12";
      if (a == 12'hFEC) begin tag = "R11"; return 32'h0210_0028; end
      if (a >= 256 && a < 256 + 8*NP && a % 4 == 0) begin
         int n = (a - 256) / 8;
         if (a % 8 == 0) begin tag = "R4"; return m_cfg[n]; end
         tag = "R8";
         return {25'h0, m_own[n], 3'b000, m_held[n]};
      end
      for (int g = 0; g < 4; g++) begin
         if (a == 16 + 4*g || a == 48 + 4*g) begin
            logic [31:0] w = '0;
            tag = (a < 48) ? "R2" : "R3";
            for (int b = 0; b < 32; b++)
               if (g*32 + b < NP) w[b] = (a < 48) ? m_sec[g*32+b] : m_priv[g*32+b];
            return w;
         end
      end
      return 32'h0;
   endfunction

   task automatic sweep_grants(input string phase);
      for (int k = 0; k < NP + 3; k++) begin
         int s = (k < NP + 2) ? k : 127;
         for (int c = 0; c < 8; c++)
            for (int f = 0; f < 4; f++) begin
               string tag;
               bit e;
               @(negedge clk);
               acc_slot = 7'(s); acc_cid = 3'(c); acc_sec = f[0]; acc_priv = f[1];
               #5;
               e = exp_grant(s, c, f[0], f[1], tag);
               checks++;
               if (acc_grant !== e) begin
                  errors++;
                  $display("FAIL %s (%s) grant slot=%0d cid=%0d sec=%0d priv=%0d got=%b exp=%b",
                           tag, phase, s, c, f[0], f[1], acc_grant, e);
               end
            end
      end
   endtask

   task automatic check_read(input int a, input string phase);
      string tag;
      logic [31:0] e;
      @(negedge clk);
      bus_addr = 12'(a);
      #5;
      e = exp_read(a, tag);
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s (%s) read addr=%h got=%h exp=%h", tag, phase, a, bus_rdata, e);
      end
   endtask

   task automatic sweep_regs(input string phase);
      for (int n = 0; n < NP; n++) begin
         check_read(256 + 8*n, phase);
         check_read(260 + 8*n, phase);
         checks++;
         if (sem_held[n] !== m_held[n] || sem_owner[n*3 +: 3] !== m_own[n]) begin
            errors++;
            $display("FAIL R8 (%s) slot %0d outputs got=%b/%0d exp=%b/%0d", phase, n,
                     sem_held[n], sem_owner[n*3 +: 3], m_held[n], m_own[n]);
         end
      end
      foreach (check_addrs[i]) check_read(check_addrs[i], phase);
   endtask

   int check_addrs [9] = '{16, 20, 24, 48, 52, 56, 12'hFEC, 0, 12'h102};

   initial begin
      for (int n = 0; n < NP; n++) begin
         m_cfg[n] = 0; m_sec[n] = 0; m_priv[n] = 0; m_held[n] = 0; m_own[n] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, R11 and R12 read-back
      sweep_regs("R1 reset");
      sweep_grants("R1 reset");
      // R2 R3: bitmaps across both words, upper bits of word 1 have no slots
      wr(16, 32'hA5A5_0F0F, 0);
      wr(20, 32'hFFFF_FF5A, 0);
      wr(48, 32'h1234_5678, 0);
      wr(52, 32'h0000_00C5, 0);
      sweep_regs("R2 R3 bitmaps");
      sweep_grants("R2 R3 bitmaps");
      // R4 R6: fixed-owner filtering, reserved bits written high
      wr(256 + 8*5, 32'hFF00_0031, 0);
      wr(256 + 8*6, 32'hFFFF_FF71 & ~32'h2, 0);
      wr(256 + 8*39, 32'h0000_0001, 0);
      sweep_regs("R4 R6 static");
      sweep_grants("R4 R6 static");
      // R7 R8 R9 R10: semaphore slot 33, whitelist CIDs 1,2,5, fixed CID 2 ignored
      wr(256 + 8*33, 32'h0026_0023, 0);
      wr(260 + 8*33, 32'h1, 0);            // R10 not whitelisted
      sweep_regs("R10 non-whitelisted");
      sweep_grants("R7 no holder");
      wr(260 + 8*33, 32'h1, 2);            // R8 take
      sweep_regs("R8 take");
      sweep_grants("R7 held by 2");
      wr(260 + 8*33, 32'h1, 5);            // R10 rival
      wr(260 + 8*33, 32'h0, 2);            // R10 bit 0 clear
      wr(260 + 8*6, 32'h1, 7);             // R10 semaphore mode off
      sweep_regs("R10 ignored writes");
      wr(260 + 8*33, 32'h1, 2);            // R9 release
      sweep_regs("R9 release");
      wr(260 + 8*33, 32'h1, 5);            // R9 hand-over
      sweep_regs("R9 hand-over");
      sweep_grants("R7 held by 5");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule